// File: doc/BRIEF.md
# Prioritised Interrupt Entry and Return Sequencer

This block arbitrates among a set of interrupt sources for a small 8-bit processor. It also performs the hardware part of taking an exception and of returning from one. Each source presents a request flag and an enable bit. A fixed-priority arbiter picks the lowest-numbered source whose flag and enable are both set. The pick is taken only at an instruction boundary, and only while the global mask bit of the condition-code register (CCR) is clear. Any source that is not picked keeps its flag and is considered again at later boundaries.

Once it accepts a request, the sequencer asserts `busy` so the processor stalls. It writes the next-instruction address and then the CCR to a descending word stack, and writes the CCR back with the mask bit set. It then reads the handler address from a per-source vector word and loads it into the program counter. A return command reads the two stacked words in the reverse order and restores both registers.

The sequencer is a single state machine with these states: IDLE, PUSH_PC, PUSH_CCR, SET_MASK, FETCH_VEC, LOAD_PC, POP_CCR and POP_PC. Its transitions are:
- IDLE goes to PUSH_PC when a request is accepted.
- IDLE goes to POP_CCR on a return command.
- The entry chain runs PUSH_PC, PUSH_CCR, SET_MASK, FETCH_VEC, LOAD_PC and then back to IDLE, one state per clock cycle.
- The return chain runs POP_CCR, POP_PC and then back to IDLE, one state per clock cycle.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A source whose enable bit is 0 is never selected, even when its request flag is 1. A higher-numbered enabled source is taken in its place.
- R2: Among sources with both flag and enable set, the lowest index is taken. The handler address loaded into PC identifies it. A source that loses arbitration is taken at a later boundary once it wins.
- R3: While CCR bit 7 (the mask bit) is 1 on `ccr_in`, no request is accepted and `busy` stays 0.
- R4: A request is accepted only in a cycle where the sequencer is idle, `insn_done` is 1 and `rte_cmd` is 0. `busy` rises in the following cycle.
- R5: Entry writes the `pc_in` value captured at acceptance to address SP-2. It then writes the captured CCR, zero-extended to a word, to SP-4. SP starts at STACK_TOP after reset.
- R6: After both pushes, `ccr_we` writes the captured CCR with bit 7 set.
- R7: The handler address is read from word address VEC_BASE + 2*index and written to PC with `pc_we`.
- R8: `busy` is 1 for exactly 5 cycles per entry and exactly 2 cycles per return.
- R9: `rte_cmd` in the idle state reads the CCR at SP and writes it with `ccr_we`. It then reads PC at SP+2 and writes it with `pc_we`. SP ends 4 above its value before the return, and `rte_cmd` takes precedence over a request in the same cycle.
- R10: Flags and enables are sampled only in the boundary cycle. A request present in that cycle is taken even if its flag is cleared in the next cycle.
- R11: Memory writes occur only in the two push states, and CCR is always pushed at the word below PC.
- R12: After reset, `busy`, `mem_req`, `mem_we`, `pc_we` and `ccr_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_flags | input | N_SRC | Request flag per source |
| req_en | input | N_SRC | Enable bit per source |
| ccr_in | input | CW | Current CCR of the processor |
| pc_in | input | AW | Address of the next instruction |
| insn_done | input | 1 | Instruction boundary strobe |
| rte_cmd | input | 1 | Return-from-exception command |
| mem_rdata | input | AW | Read word, valid in the same cycle as `mem_req` |
| busy | output | 1 | Processor stall while a sequence runs |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | AW | Memory write word |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | AW | Program counter load value |
| ccr_we | output | 1 | CCR load strobe |
| ccr_wdata | output | CW | CCR load value |

## Verification
Assertions check the following on every cycle:
- the state ordering of both chains;
- the one-word spacing between the two stack accesses of each chain;
- that `busy` only ever starts from a boundary or a return command;
- that a set mask bit blocks entry;
- that the arbiter's choice is enabled and has no enabled lower-index rival.

Only the bench scenarios can show that the stacked values equal the captured PC and CCR, that the right handler word is loaded, and that a return restores exactly what entry saved. The same applies to the exact `busy` lengths and to a losing source surviving to a later entry.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_SET_MASK,
        ST_FETCH_VEC,
        ST_LOAD_PC,
        ST_POP_CCR,
        ST_POP_PC
    } seq_state_e;

    localparam int WORD_BYTES = 2;

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N_SRC = 8,
    parameter int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] req_flags,
    input  logic [N_SRC-1:0] req_en,
    output logic             win_valid,
    output logic [IDW-1:0]   win_id
);

    logic [N_SRC-1:0] live;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign live[g] = req_flags[g] & req_en[g];
    end

    always_comb begin
        win_valid = |live;
        win_id    = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i]) win_id = IDW'(i);
        end
    end

    // Checks that the winner is enabled and that no enabled lower index exists.
    always_comb begin
        if (win_valid) begin
            assert_grant_enabled_R1: assert (req_flags[win_id] && req_en[win_id]);
            for (int k = 0; k < N_SRC; k++) begin
                if (k < int'(win_id)) begin
                    assert_no_better_R2: assert (!(req_flags[k] && req_en[k]));
                end
            end
        end
    end

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int             AW       = 16,
    parameter int             IDW      = 3,
    parameter logic [AW-1:0]  VEC_BASE = 16'h0040
) (
    input  logic [IDW-1:0] src_id,
    output logic [AW-1:0]  vec_addr
);

    localparam int SHIFT = $clog2(irq_seq_pkg::WORD_BYTES);

    always_comb begin
        vec_addr = VEC_BASE + (AW'(src_id) << SHIFT);
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int             AW        = 16,
    parameter int             CW        = 8,
    parameter int             IDW       = 3,
    parameter int             IBIT      = 7,
    parameter logic [AW-1:0]  STACK_TOP = 16'hFF00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_done,
    input  logic            rte_cmd,
    input  logic            win_valid,
    input  logic [IDW-1:0]  win_id,
    input  logic [CW-1:0]   ccr_in,
    input  logic [AW-1:0]   pc_in,
    input  logic [AW-1:0]   vec_addr,
    input  logic [AW-1:0]   mem_rdata,
    output logic [IDW-1:0]  cur_id,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [AW-1:0]   mem_wdata,
    output logic            pc_we,
    output logic [AW-1:0]   pc_wdata,
    output logic            ccr_we,
    output logic [CW-1:0]   ccr_wdata
);

    localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);
    localparam logic [CW-1:0] I_MASK = CW'(1) << IBIT;

    seq_state_e      state, state_nx;
    logic [AW-1:0]   sp;
    logic [AW-1:0]   saved_pc;
    logic [CW-1:0]   saved_ccr;
    logic [AW-1:0]   handler;
    logic            accept;
    logic            start_ret;

    assign start_ret = (state == ST_IDLE) && rte_cmd;
    assign accept    = (state == ST_IDLE) && insn_done && !rte_cmd &&
                       win_valid && !ccr_in[IBIT];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ret)   state_nx = ST_POP_CCR;
                else if (accept) state_nx = ST_PUSH_PC;
            end
            ST_PUSH_PC:   state_nx = ST_PUSH_CCR;
            ST_PUSH_CCR:  state_nx = ST_SET_MASK;
            ST_SET_MASK:  state_nx = ST_FETCH_VEC;
            ST_FETCH_VEC: state_nx = ST_LOAD_PC;
            ST_LOAD_PC:   state_nx = ST_IDLE;
            ST_POP_CCR:   state_nx = ST_POP_PC;
            ST_POP_PC:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Context and stack pointer registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp        <= STACK_TOP;
            saved_pc  <= '0;
            saved_ccr <= '0;
            cur_id    <= '0;
            handler   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        saved_pc  <= pc_in;
                        saved_ccr <= ccr_in;
                        cur_id    <= win_id;
                    end
                end
                ST_PUSH_PC, ST_PUSH_CCR: sp <= sp - STEP;
                ST_FETCH_VEC:            handler <= mem_rdata;
                ST_POP_CCR, ST_POP_PC:   sp <= sp + STEP;
                default: ;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy      = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_wdata  = '0;
        ccr_we    = 1'b0;
        ccr_wdata = '0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - STEP;
                mem_wdata = saved_pc;
            end
            ST_PUSH_CCR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp - STEP;
                mem_wdata = {{(AW-CW){1'b0}}, saved_ccr};
            end
            ST_SET_MASK: begin
                ccr_we    = 1'b1;
                ccr_wdata = saved_ccr | I_MASK;
            end
            ST_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_LOAD_PC: begin
                pc_we    = 1'b1;
                pc_wdata = handler;
            end
            ST_POP_CCR: begin
                mem_req   = 1'b1;
                mem_addr  = sp;
                ccr_we    = 1'b1;
                ccr_wdata = mem_rdata[CW-1:0];
            end
            ST_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = sp;
                pc_we    = 1'b1;
                pc_wdata = mem_rdata;
            end
            default: busy = 1'b0;
        endcase
    end

    assert_busy_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done || rte_cmd));

    assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !rte_cmd && ccr_in[IBIT]) |=> !busy);

    assert_no_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_done && !rte_cmd) |=> !busy);

    assert_ccr_below_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_CCR) |-> ($past(state) == ST_PUSH_PC &&
                                    mem_addr == $past(mem_addr) - STEP));

    assert_mask_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_we && !mem_req |-> ($past(state) == ST_PUSH_CCR && ccr_wdata[IBIT]));

    assert_vec_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !mem_req) |-> ($past(mem_req) && !$past(mem_we) &&
                                 $past(mem_addr) == $past(vec_addr)));

    assert_pop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_PC) |-> ($past(state) == ST_POP_CCR &&
                                  mem_addr == $past(mem_addr) + STEP));

    assert_entry_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !mem_req) |=> !busy);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
    parameter int             N_SRC     = 8,
    parameter int             AW        = 16,
    parameter int             CW        = 8,
    parameter int             IBIT      = 7,
    parameter logic [AW-1:0]  VEC_BASE  = 16'h0040,
    parameter logic [AW-1:0]  STACK_TOP = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_flags,
    input  logic [N_SRC-1:0]  req_en,
    input  logic [CW-1:0]     ccr_in,
    input  logic [AW-1:0]     pc_in,
    input  logic              insn_done,
    input  logic              rte_cmd,
    input  logic [AW-1:0]     mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_wdata,
    output logic              pc_we,
    output logic [AW-1:0]     pc_wdata,
    output logic              ccr_we,
    output logic [CW-1:0]     ccr_wdata
);

    localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic           win_valid;
    logic [IDW-1:0] win_id;
    logic [IDW-1:0] cur_id;
    logic [AW-1:0]  vec_addr;

    irq_prio_arb #(.N_SRC(N_SRC), .IDW(IDW)) arb_i (
        .req_flags (req_flags),
        .req_en    (req_en),
        .win_valid (win_valid),
        .win_id    (win_id)
    );

    irq_vec_gen #(.AW(AW), .IDW(IDW), .VEC_BASE(VEC_BASE)) vec_i (
        .src_id   (cur_id),
        .vec_addr (vec_addr)
    );

    irq_seq_fsm #(
        .AW(AW), .CW(CW), .IDW(IDW), .IBIT(IBIT), .STACK_TOP(STACK_TOP)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .rte_cmd   (rte_cmd),
        .win_valid (win_valid),
        .win_id    (win_id),
        .ccr_in    (ccr_in),
        .pc_in     (pc_in),
        .vec_addr  (vec_addr),
        .mem_rdata (mem_rdata),
        .cur_id    (cur_id),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata),
        .ccr_we    (ccr_we),
        .ccr_wdata (ccr_wdata)
    );

endmodule

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb_top;

    localparam int            CLK_PERIOD = 10;
    localparam int            N_SRC      = 8;
    localparam logic [15:0]   VEC_BASE   = 16'h0040;
    localparam logic [15:0]   STACK_TOP  = 16'h0400;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] en;
        logic       ibit;
        logic       take;
        logic [2:0] id;
    } vec_t;

    // flags, en, mask bit, taken?, expected source
    localparam vec_t VECS [8] = '{
        '{8'h01, 8'hFF, 1'b0, 1'b1, 3'd0},  // R2 single source 0
        '{8'h06, 8'hFF, 1'b0, 1'b1, 3'd1},  // R2 lowest index wins
        '{8'h04, 8'hFF, 1'b0, 1'b1, 3'd2},  // R2 loser still pending
        '{8'h80, 8'h7F, 1'b0, 1'b0, 3'd0},  // R1 disabled source ignored
        '{8'h81, 8'hFE, 1'b0, 1'b1, 3'd7},  // R1 enabled higher index taken
        '{8'h10, 8'hFF, 1'b1, 1'b0, 3'd0},  // R3 mask bit set
        '{8'h00, 8'hFF, 1'b0, 1'b0, 3'd0},  // R4 nothing requested
        '{8'hF0, 8'h30, 1'b0, 1'b1, 3'd4}   // R1 R2 mixed enables
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_flags = '0;
    logic [7:0]  req_en = '0;
    logic [7:0]  ccr_in = '0;
    logic [15:0] pc_in = '0;
    logic        insn_done = 1'b0;
    logic        rte_cmd = 1'b0;
    logic [15:0] mem_rdata;
    logic        busy, mem_req, mem_we, pc_we, ccr_we;
    logic [15:0] mem_addr, mem_wdata, pc_wdata;
    logic [7:0]  ccr_wdata;

    logic [15:0] mem [512];

    int n_chk = 0;
    int n_fail = 0;
    int mon_busy = 0;
    int mon_pc_cnt = 0;
    int mon_we_cnt = 0;
    logic [15:0] mon_pc = '0;
    logic [7:0]  mon_ccr = '0;
    logic [15:0] first_addr = '0;
    bit          first_seen = 1'b0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_ctrl #(
        .N_SRC(N_SRC), .AW(16), .CW(8), .IBIT(7),
        .VEC_BASE(VEC_BASE), .STACK_TOP(STACK_TOP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .req_en(req_en),
        .ccr_in(ccr_in), .pc_in(pc_in), .insn_done(insn_done), .rte_cmd(rte_cmd),
        .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_we(pc_we),
        .pc_wdata(pc_wdata), .ccr_we(ccr_we), .ccr_wdata(ccr_wdata)
    );

    assign mem_rdata = mem[mem_addr[9:1]];

    always @(posedge clk) begin
        if (busy) mon_busy++;
        if (pc_we) begin mon_pc = pc_wdata; mon_pc_cnt++; end
        if (ccr_we) mon_ccr = ccr_wdata;
        if (mem_req && mem_we) begin
            mem[mem_addr[9:1]] = mem_wdata;
            mon_we_cnt++;
            if (!first_seen) begin first_addr = mem_addr; first_seen = 1'b1; end
        end
    end

    function automatic logic [15:0] handler_of(input int id);
        return 16'h1000 + 16'(id * 256);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_busy = 0; mon_pc_cnt = 0; mon_we_cnt = 0; first_seen = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic run_case(input vec_t v, input logic [15:0] pcv, input bit drop_flags);
        logic [7:0] ccr_v;
        ccr_v = {v.ibit, 7'h15};
        @(negedge clk);
        req_flags = v.flags; req_en = v.en; ccr_in = ccr_v; pc_in = pcv;
        insn_done = 1'b1;
        clear_mon();
        @(negedge clk);
        insn_done = 1'b0;
        if (drop_flags) req_flags = '0;
        chk(busy == v.take, "R4 R3 R1 acceptance", 32'(busy), 32'(v.take));
        if (v.take) begin
            wait_idle();
            chk(mon_busy == 5, "R8 entry busy length", 32'(mon_busy), 32'd5);
            chk(first_addr == STACK_TOP - 16'd2, "R5 first push address",
                32'(first_addr), 32'(STACK_TOP - 16'd2));
            chk(mem[(STACK_TOP - 16'd2) >> 1] == pcv, "R5 stacked PC",
                32'(mem[(STACK_TOP - 16'd2) >> 1]), 32'(pcv));
            chk(mem[(STACK_TOP - 16'd4) >> 1] == {8'h00, ccr_v}, "R5 R11 stacked CCR",
                32'(mem[(STACK_TOP - 16'd4) >> 1]), 32'(ccr_v));
            chk(mon_ccr == (ccr_v | 8'h80), "R6 mask set", 32'(mon_ccr),
                32'(ccr_v | 8'h80));
            chk(mon_pc == handler_of(int'(v.id)), "R7 R2 handler loaded",
                32'(mon_pc), 32'(handler_of(int'(v.id))));
            clear_mon();
            @(negedge clk); rte_cmd = 1'b1;
            @(negedge clk); rte_cmd = 1'b0;
            wait_idle();
            chk(mon_busy == 2, "R8 return busy length", 32'(mon_busy), 32'd2);
            chk(mon_ccr == ccr_v, "R9 CCR restored", 32'(mon_ccr), 32'(ccr_v));
            chk(mon_pc == pcv, "R9 PC restored", 32'(mon_pc), 32'(pcv));
            chk(mon_we_cnt == 0, "R11 no writes on return", 32'(mon_we_cnt), 32'd0);
        end else begin
            repeat (3) @(negedge clk);
            chk(!busy && mon_pc_cnt == 0, "R1 R3 R4 nothing taken",
                32'(mon_pc_cnt), 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
        for (int i = 0; i < N_SRC; i++) mem[(VEC_BASE >> 1) + 16'(i)] = handler_of(i);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !mem_req && !mem_we && !pc_we && !ccr_we, "R12 in reset",
            {27'd0, busy, mem_req, mem_we, pc_we, ccr_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !pc_we && !ccr_we, "R12 after reset",
            {28'd0, busy, mem_req, pc_we, ccr_we}, 32'd0);

        for (int k = 0; k < 8; k++) begin
            run_case(VECS[k], 16'h2000 + 16'(k * 34), 1'b0);
        end

        // R4: enabled request with no boundary strobe
        @(negedge clk);
        req_flags = 8'h02; req_en = 8'hFF; ccr_in = 8'h00; clear_mon();
        repeat (4) @(negedge clk);
        chk(!busy && mon_pc_cnt == 0, "R4 no boundary no entry", 32'(busy), 32'd0);

        // R10: flag cleared right after the boundary cycle
        run_case('{8'h08, 8'hFF, 1'b0, 1'b1, 3'd3}, 16'h3456, 1'b1);

        // R9 R4: return command wins over a boundary in the same cycle
        @(negedge clk);
        req_flags = 8'h01; req_en = 8'hFF; ccr_in = 8'h00;
        insn_done = 1'b1; rte_cmd = 1'b1; clear_mon();
        @(negedge clk);
        insn_done = 1'b0; rte_cmd = 1'b0;
        wait_idle();
        chk(mon_busy == 2 && mon_we_cnt == 0, "R9 return has precedence",
            32'(mon_busy), 32'd2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule